// File: doc/BRIEF.md
# Program-Flow Sequencer with Conditional Branches

This block owns the program counter of a small accumulator machine and decides where execution goes next. Each cycle in which `step` is high it looks at one instruction word. If the top nibble is nonzero the instruction belongs to another unit and the counter advances by one. If the top nibble is zero, bits 11:8 select a flow operation. It can be an absolute jump or a subroutine call whose 16-bit target comes from the word that follows the instruction. It can be a short relative branch that tests the signed accumulator. It can also be a return that takes its address from an internal return-address stack.

The memory fetch stays outside the block. The caller presents the current instruction, the accumulator, and the word stored at PC+1 together with `step`. The new counter appears on `pc` after the next rising edge. The return stack holds a fixed number of entries. A call on a full stack or a return on an empty stack sets a sticky error flag and leaves the stack untouched.

Top module: `flow_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` takes the value `RESET_PC` (default 0x0000), `stack_err` clears and the return stack empties.
- R2: With `step` low, `pc` holds its value. With `step` high and `instr[15:12]` nonzero, `pc` becomes `pc+1`.
- R3: Code 0x00 (`instr[15:8]`=0x00) loads `pc` with `next_word`. The payload `instr[7:0]` is ignored.
- R4: Codes 0x01 to 0x07 are relative branches on the two's-complement accumulator: 0x01 acc>0, 0x02 acc<0, 0x03 acc≠0, 0x04 acc=0, 0x05 acc≥0, 0x06 acc≤0, 0x07 always. A taken branch loads `pc+1+sext(instr[7:0])`. A branch that is not taken loads `pc+1`.
- R5: All address arithmetic wraps modulo 2^16, including relative targets and the return address of a call.
- R6: Code 0x08 loads `pc` with `next_word` and pushes `pc+2` onto the return stack. The payload is ignored.
- R7: Code 0x09 on a non-empty stack loads `pc` with the most recently pushed address and removes it.
- R8: Returns come back in last-in, first-out order through up to `DEPTH` (default 8) nested calls.
- R9: A call while `DEPTH` entries are held sets `stack_err` and still jumps to `next_word`. The stored entries are not changed.
- R10: A return on an empty stack sets `stack_err` and advances `pc` by one.
- R11: Codes 0x0A to 0x0F advance `pc` by one and leave the return stack untouched.
- R12: `stack_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Instruction on `instr` is to be executed this cycle |
| instr | input | 16 | Current instruction word |
| acc | input | 16 | Accumulator, read as a signed value |
| next_word | input | 16 | Memory word at PC+1 (absolute target) |
| pc | output | 16 | Program counter |
| stack_err | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
Overflow is the hardest state to reach from the ports. It needs eight nested calls before the ninth one can fail, and the check then needs all eight returns to show that the failed call changed nothing. The stimulus builds this chain with distinct call targets and tracks the expected return addresses. It places an unassigned code in the middle of the chain, then unwinds the chain and goes one return further to reach underflow. The branch sweep crosses every condition with boundary accumulator values (0, ±1, 0x7FFF, 0x8000) and extreme offsets. It uses base addresses chosen so that targets wrap in both directions.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [2:0] {
        FK_IDLE,
        FK_SEQ,
        FK_JUMP,
        FK_BRANCH,
        FK_CALL,
        FK_RET
    } flow_kind_e;

    typedef enum logic [2:0] {
        CC_NONE = 3'd0,
        CC_GT   = 3'd1,
        CC_LT   = 3'd2,
        CC_NZ   = 3'd3,
        CC_Z    = 3'd4,
        CC_GE   = 3'd5,
        CC_LE   = 3'd6,
        CC_ALL  = 3'd7
    } cond_code_e;

    typedef struct packed {
        flow_kind_e kind;
        cond_code_e cond;
    } flow_dec_t;

    localparam logic [3:0] SUB_JUMP = 4'h0;
    localparam logic [3:0] SUB_CALL = 4'h8;
    localparam logic [3:0] SUB_RET  = 4'h9;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic          step,
    input  logic [IW-1:0] instr,
    output flow_dec_t     dec
);
    localparam int GRP_HI = IW - 1;
    localparam int GRP_LO = IW - 4;
    localparam int SUB_HI = IW - 5;
    localparam int SUB_LO = IW - 8;

    logic [3:0] grp;
    logic [3:0] sub;

    assign grp = instr[GRP_HI:GRP_LO];
    assign sub = instr[SUB_HI:SUB_LO];

    always_comb begin
        dec.kind = FK_IDLE;
        dec.cond = CC_NONE;
        if (step) begin
            if (grp != 4'h0) begin
                dec.kind = FK_SEQ;
            end else if (sub == SUB_JUMP) begin
                dec.kind = FK_JUMP;
            end else if (sub[3] == 1'b0) begin
                dec.kind = FK_BRANCH;
                dec.cond = cond_code_e'(sub[2:0]);
            end else if (sub == SUB_CALL) begin
                dec.kind = FK_CALL;
            end else if (sub == SUB_RET) begin
                dec.kind = FK_RET;
            end else begin
                dec.kind = FK_SEQ;
            end
        end
    end
endmodule

// File: rtl/flow_cond.sv
module flow_cond
    import flow_pkg::*;
#(
    parameter int DW = 16
) (
    input  cond_code_e    cond,
    input  logic [DW-1:0] acc,
    output logic          taken
);
    logic neg;
    logic zero;

    assign neg  = acc[DW-1];
    assign zero = (acc == '0);

    always_comb begin
        case (cond)
            CC_GT:   taken = !neg && !zero;
            CC_LT:   taken = neg;
            CC_NZ:   taken = !zero;
            CC_Z:    taken = zero;
            CC_GE:   taken = !neg;
            CC_LE:   taken = neg || zero;
            CC_ALL:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int AW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          empty,
    output logic          err
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0]  count;
    logic [AW-1:0]  slot [DEPTH];
    logic           full;
    logic [IXW-1:0] rd_idx;

    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);
    assign rd_idx = IXW'(count - 1'b1);
    assign top_data = empty ? '0 : slot[rd_idx];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot[i] <= '0;
                end else if (push && !full && count == CW'(i)) begin
                    slot[i] <= push_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            if (push) begin
                if (full) err <= 1'b1;
                else      count <= count + 1'b1;
            end else if (pop) begin
                if (empty) err <= 1'b1;
                else       count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          IW       = 16,
    parameter int          DW       = 16,
    parameter int          DEPTH    = 8,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] acc,
    input  logic [AW-1:0] next_word,
    output logic [AW-1:0] pc,
    output logic          stack_err
);
    localparam int OW = IW / 2;

    flow_dec_t     dec;
    logic          taken;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] pc_ret_addr;
    logic [AW-1:0] pc_rel;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] pc_nxt;
    logic [AW-1:0] top_data;
    logic          stk_empty;
    logic          do_push;
    logic          do_pop;

    flow_decode #(.IW(IW)) u_dec (
        .step  (step),
        .instr (instr),
        .dec   (dec)
    );

    flow_cond #(.DW(DW)) u_cond (
        .cond  (dec.cond),
        .acc   (acc),
        .taken (taken)
    );

    assign do_push = (dec.kind == FK_CALL);
    assign do_pop  = (dec.kind == FK_RET);

    ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (pc_ret_addr),
        .top_data  (top_data),
        .empty     (stk_empty),
        .err       (stack_err)
    );

    assign off_ext     = {{(AW-OW){instr[OW-1]}}, instr[OW-1:0]};
    assign pc_inc      = pc + AW'(1);
    assign pc_ret_addr = pc + AW'(2);
    assign pc_rel      = pc_inc + off_ext;

    always_comb begin
        case (dec.kind)
            FK_SEQ:    pc_nxt = pc_inc;
            FK_JUMP:   pc_nxt = next_word;
            FK_BRANCH: pc_nxt = taken ? pc_rel : pc_inc;
            FK_CALL:   pc_nxt = next_word;
            FK_RET:    pc_nxt = stk_empty ? pc_inc : top_data;
            default:   pc_nxt = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= AW'(RESET_PC);
        else     pc <= pc_nxt;
    end
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
    parameter int          AW       = 16,
    parameter int          IW       = 16,
    parameter int          DW       = 16,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input logic          clk,
    input logic          rst,
    input logic          step,
    input logic [IW-1:0] instr,
    input logic [DW-1:0] acc,
    input logic [AW-1:0] next_word,
    input logic [AW-1:0] pc,
    input logic          stack_err
);
    localparam int OW = IW / 2;

    logic [7:0] op;
    logic       is_flow;
    assign op      = instr[IW-1:IW-8];
    assign is_flow = (instr[IW-1:IW-4] == 4'h0);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (pc == AW'(RESET_PC) && !stack_err));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc));

    p_seq_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !is_flow) |=> pc == AW'($past(pc) + 1'b1));

    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (step && op == 8'h00) |=> pc == $past(next_word));

    p_always_r4: assert property (@(posedge clk) disable iff (rst)
        (step && op == 8'h07) |=>
        pc == AW'($past(pc) + 1'b1 + {{(AW-OW){$past(instr[OW-1])}}, $past(instr[OW-1:0])}));

    p_zero_nt_r4: assert property (@(posedge clk) disable iff (rst)
        (step && op == 8'h03 && acc == '0) |=> pc == AW'($past(pc) + 1'b1));

    p_call_r6: assert property (@(posedge clk) disable iff (rst)
        (step && op == 8'h08) |=> pc == $past(next_word));

    p_unused_r11: assert property (@(posedge clk) disable iff (rst)
        (step && is_flow && op[3:0] >= 4'hA) |=> pc == AW'($past(pc) + 1'b1));

    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> stack_err);
endmodule

bind flow_seq flow_seq_chk #(
    .AW(AW), .IW(IW), .DW(DW), .RESET_PC(RESET_PC)
) u_chk (
    .clk(clk), .rst(rst), .step(step), .instr(instr), .acc(acc),
    .next_word(next_word), .pc(pc), .stack_err(stack_err)
);

// File: tb/flow_seq_bench.sv
module flow_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] acc = '0;
    logic [15:0] next_word = '0;
    logic [15:0] pc;
    logic        stack_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] model_stk [8];
    int          model_cnt;

    flow_seq u_flow_seq (
        .clk(clk), .rst(rst), .step(step), .instr(instr), .acc(acc),
        .next_word(next_word), .pc(pc), .stack_err(stack_err)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_cnt = 0;
    endtask

    task automatic exec(input logic [15:0] ins, input logic [15:0] a, input logic [15:0] nw);
        instr = ins; acc = a; next_word = nw; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    function automatic bit cond_ok(input int c, input logic [15:0] a);
        int s;
        s = int'($signed(a));
        case (c)
            1: return s > 0;
            2: return s < 0;
            3: return s != 0;
            4: return s == 0;
            5: return s >= 0;
            6: return s <= 0;
            default: return 1'b1;
        endcase
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] accs [7];
        logic [7:0]  offs [6];
        logic [15:0] bases [3];
        logic [15:0] exp_pc;
        logic [15:0] p0;
        accs  = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0005, 16'hFFFB};
        offs  = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hF0};
        bases = '{16'h1000, 16'hFFF8, 16'h0004};

        do_reset();
        check("R1 pc after reset", pc, 16'h0000);
        check("R1 err after reset", {15'd0, stack_err}, 16'h0000);

        repeat (3) @(negedge clk);
        check("R2 idle hold", pc, 16'h0000);

        // Branch sweep over conditions, accumulators, offsets and bases
        for (int b = 0; b < 3; b++) begin
            for (int c = 1; c < 8; c++) begin
                for (int ai = 0; ai < 7; ai++) begin
                    for (int oi = 0; oi < 6; oi++) begin
                        exec(16'h00A5, 16'h1234, bases[b]);
                        check("R3 jump", pc, bases[b]);
                        exp_pc = bases[b] + 16'd1;
                        if (cond_ok(c, accs[ai]))
                            exp_pc = exp_pc + {{8{offs[oi][7]}}, offs[oi]};
                        exec({4'h0, 4'(c), offs[oi]}, accs[ai], 16'hDEAD);
                        check(b == 0 ? "R4 branch" : "R5 branch wrap", pc, exp_pc);
                    end
                end
            end
        end

        // Instructions of other groups advance by one
        for (int g = 1; g < 16; g++) begin
            p0 = pc;
            exec({4'(g), 4'h3, 8'h55}, 16'h0000, 16'hBEEF);
            check("R2 non-flow advance", pc, p0 + 16'd1);
        end

        // Unassigned flow codes advance by one
        for (int u = 10; u < 16; u++) begin
            p0 = pc;
            exec({4'h0, 4'(u), 8'h80}, 16'h0000, 16'h4444);
            check("R11 unassigned advance", pc, p0 + 16'd1);
        end

        // Nested calls to full depth
        do_reset();
        exec(16'h0000, 16'h0, 16'h0100);
        check("R3 jump to 0100", pc, 16'h0100);
        for (int k = 0; k < 8; k++) begin
            p0 = pc;
            model_stk[model_cnt] = p0 + 16'd2;
            model_cnt++;
            exec(16'h0833, 16'h0, 16'h2000 + 16'(k * 16));
            check("R6 call target", pc, 16'h2000 + 16'(k * 16));
            if (k == 4) begin
                exec(16'h0C00, 16'h0, 16'h0);
                check("R11 unassigned mid-chain", pc, 16'h2041);
            end
        end
        check("R6 no error at full depth", {15'd0, stack_err}, 16'h0000);
        exec(16'h0800, 16'h0, 16'h3000);
        check("R9 overflow still jumps", pc, 16'h3000);
        check("R9 overflow flag", {15'd0, stack_err}, 16'h0001);
        for (int k = 0; k < 8; k++) begin
            model_cnt--;
            exec(16'h0900, 16'h0, 16'h0);
            check(k == 0 ? "R7 return" : "R8 lifo return", pc, model_stk[model_cnt]);
        end
        p0 = pc;
        exec(16'h0900, 16'h0, 16'h0);
        check("R10 underflow advance", pc, p0 + 16'd1);
        check("R12 flag held", {15'd0, stack_err}, 16'h0001);

        // Underflow alone from reset
        do_reset();
        check("R1 flag cleared", {15'd0, stack_err}, 16'h0000);
        exec(16'h0900, 16'h0, 16'h0);
        check("R10 underflow pc", pc, 16'h0001);
        check("R10 underflow flag", {15'd0, stack_err}, 16'h0001);
        exec(16'h0000, 16'h0, 16'h0500);
        exec(16'h0703, 16'h0, 16'h0);
        check("R4 branch after error", pc, 16'h0504);
        check("R12 flag sticky", {15'd0, stack_err}, 16'h0001);

        // Return address wraps
        do_reset();
        exec(16'h0000, 16'h0, 16'hFFFF);
        exec(16'h0800, 16'h0, 16'h0040);
        check("R6 call from top", pc, 16'h0040);
        exec(16'h0900, 16'h0, 16'h0);
        check("R5 return address wrap", pc, 16'h0001);
        check("R7 clean return", {15'd0, stack_err}, 16'h0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule